// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the host side of a serial link to an eight-channel, 12-bit successive-approximation converter. Each frame pulls chip select low. That one event starts a conversion and brackets the whole transfer. During the frame the block sends a 16-bit control word on the data-in line and reads back a 16-bit result on the data-out line. The returned word holds a marker bit, a channel tag and the conversion value. The controller splits it and hands the channel number and the decoded sample to the downstream logic on a valid/ready stream.

The control fields come in as plain configuration pins. They are channel address, sequencer enable, shadow mode, double input span, two's-complement coding and the write-enable bit. The serial clock comes from the system clock through a programmable half-period divider. A configurable idle gap between frames gives the converter time to acquire the next input. The result stream uses back-pressure. A result stays on the outputs, unchanged, until it is accepted. No new frame starts while a result is still waiting, so the block never drops a sample.

Top module: `sadc_host`

## Requirements
- R1: While reset is held and right after it, `adc_cs_n` is 1, `adc_sclk` is 1, `adc_din` is 0 and `res_valid` is 0.
- R2: A frame starts (falling `adc_cs_n`) only on a clock edge where `en` is 1, `res_valid` is 0 and chip select has already been high for more than `cfg_gap` system clocks. The gap count saturates at its maximum.
- R3: `adc_sclk` stays high whenever `adc_cs_n` is high. In a frame, with H = `cfg_half` (0 is treated as 1), chip select is low for exactly 32·H clocks. Those clocks form 32 half-periods of H clocks each, alternating and starting with a high half.
- R4: The control word goes out MSB first, and bit k (counting from the MSB) is on `adc_din` during half-periods 2k and 2k+1. The word is: bit15 `cfg_write`, bit14 `cfg_seq`, bit13 0, bits12:10 `cfg_addr`, bits9:8 both 1 (normal power), bit7 `cfg_shadow`, bit6 0, bit5 `cfg_range`, bit4 `cfg_coding`, bits3:0 zero. Between frames `adc_din` is 0.
- R5: The control fields, `cfg_coding` and `cfg_half` are captured when the frame starts. Changing them during a frame has no effect on that frame.
- R6: `adc_dout` is sampled in the last system clock of each high half-period, giving 16 bits MSB first. Bits14:12 of the received word appear on `res_chan`.
- R7: `res_tag_err` is set for a result whose received bit15 (the marker bit) is 1.
- R8: With coding 0, `res_sample` is the 12-bit value zero-extended to 13 bits. With coding 1, it is the value sign-extended from bit11. `res_twos` shows which coding applied.
- R9: `res_valid` rises on the edge where `adc_cs_n` rises. It and all result fields hold steady until a cycle with `res_ready` high, and `res_valid` falls after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Allow frames to start |
| cfg_half | input | DIV_W | SCLK half-period in system clocks |
| cfg_gap | input | GAP_W | Minimum chip-select high time, minus one |
| cfg_write | input | 1 | Control word write-enable bit |
| cfg_seq | input | 1 | Sequencer enable bit |
| cfg_shadow | input | 1 | Shadow mode bit |
| cfg_addr | input | 3 | Channel address |
| cfg_range | input | 1 | Double input span |
| cfg_coding | input | 1 | Two's-complement output coding |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_din | output | 1 | Serial control word to converter |
| adc_dout | input | 1 | Serial result from converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Downstream accepts result |
| res_chan | output | 3 | Channel tag of result |
| res_sample | output | 13 | Decoded sample |
| res_twos | output | 1 | Sample is signed |
| res_tag_err | output | 1 | Marker bit was not zero |

## Verification
The hardest situation to reach is a configuration change landing in the middle of a frame while a back-pressured result holds the next frame back. That is the only way to see the start-of-frame capture and the start gating act together. The stimulus waits until chip select is low and then rewrites coding, address and divider while the frame runs. It drops `res_ready` for a long stretch and later releases it. A behavioural converter model on the serial pins plays back planned result words, including marker-bit errors and the coding extremes 0x800, 0x7FF and 0xFFF. The bench's reference model predicts every pin on every clock.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int FRAME_BITS = 16;
  localparam int DATA_W     = 12;
  localparam int CH_W       = 3;
  localparam int HALF_CNT   = 2 * FRAME_BITS;
  localparam int PH_W       = $clog2(HALF_CNT);

  typedef struct packed {
    logic            wr;
    logic            seq;
    logic [CH_W-1:0] addr;
    logic            shadow;
    logic            range_dbl;
    logic            twos;
  } ctrl_t;

  // field positions are decoded by the converter
  function automatic logic [FRAME_BITS-1:0] pack_ctrl(input ctrl_t c);
    return {c.wr, c.seq, 1'b0, c.addr, 2'b11, c.shadow, 1'b0,
            c.range_dbl, c.twos, 4'b0000};
  endfunction
endpackage

// File: rtl/sadc_timing.sv
module sadc_timing
  import sadc_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hold_off,
  input  logic [DIV_W-1:0] half_div,
  input  logic [GAP_W-1:0] gap_min,
  output logic             cs_n,
  output logic             sclk,
  output logic             go,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             done
);
  localparam logic [GAP_W-1:0] GMAX = {GAP_W{1'b1}};

  logic             active;
  logic [DIV_W-1:0] tcnt;
  logic [DIV_W-1:0] hlat;
  logic [DIV_W-1:0] half_eff;
  logic [PH_W-1:0]  ph;
  logic [GAP_W-1:0] gcnt;
  logic             end_half;
  logic             last_ph;

  assign half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
  assign end_half = active && (tcnt == hlat - DIV_W'(1));
  assign last_ph  = (ph == PH_W'(HALF_CNT - 1));
  assign go       = !active && en && !hold_off && (gcnt >= gap_min);
  assign fall_stb = end_half && !ph[0];
  assign rise_stb = end_half && ph[0] && !last_ph;
  assign done     = end_half && ph[0] && last_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cs_n   <= 1'b1;
      sclk   <= 1'b1;
      tcnt   <= '0;
      hlat   <= DIV_W'(1);
      ph     <= '0;
      gcnt   <= '0;
    end else if (go) begin
      active <= 1'b1;
      cs_n   <= 1'b0;
      tcnt   <= '0;
      ph     <= '0;
      hlat   <= half_eff;
    end else if (active) begin
      if (end_half) begin
        tcnt <= '0;
        ph   <= ph + PH_W'(1);
        sclk <= ph[0];
        if (done) begin
          active <= 1'b0;
          cs_n   <= 1'b1;
          gcnt   <= '0;
        end
      end else begin
        tcnt <= tcnt + DIV_W'(1);
      end
    end else if (gcnt != GMAX) begin
      gcnt <= gcnt + GAP_W'(1);
    end
  end
endmodule

// File: rtl/sadc_shift.sv
module sadc_shift
  import sadc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic                  rise_stb,
  input  logic                  fall_stb,
  input  logic                  done,
  input  logic [FRAME_BITS-1:0] load_word,
  input  logic                  dout,
  output logic                  din,
  output logic [FRAME_BITS-1:0] rx
);
  logic [FRAME_BITS-1:0] tx;

  assign din = tx[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx <= '0;
      rx <= '0;
    end else begin
      if (go)            tx <= load_word;
      else if (rise_stb) tx <= {tx[FRAME_BITS-2:0], 1'b0};
      else if (done)     tx <= '0;

      if (go)            rx <= '0;
      else if (fall_stb) rx <= {rx[FRAME_BITS-2:0], dout};
    end
  end
endmodule

// File: rtl/sadc_result.sv
module sadc_result
  import sadc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic                  twos_in,
  input  logic                  done,
  input  logic [FRAME_BITS-1:0] rx,
  input  logic                  ready,
  output logic                  valid,
  output logic [CH_W-1:0]       chan,
  output logic [DATA_W:0]       sample,
  output logic                  twos,
  output logic                  tag_err
);
  localparam int MARK_POS = DATA_W + CH_W;

  logic             twos_lat;
  logic [DATA_W-1:0] value;
  logic [DATA_W:0]   ext;

  assign value = rx[DATA_W-1:0];
  assign ext   = twos_lat ? {value[DATA_W-1], value} : {1'b0, value};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      twos_lat <= 1'b0;
      valid    <= 1'b0;
      chan     <= '0;
      sample   <= '0;
      twos     <= 1'b0;
      tag_err  <= 1'b0;
    end else begin
      if (go) twos_lat <= twos_in;
      if (done) begin
        valid   <= 1'b1;
        chan    <= rx[DATA_W +: CH_W];
        sample  <= ext;
        twos    <= twos_lat;
        tag_err <= rx[MARK_POS];
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sadc_host.sv
module sadc_host
  import sadc_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic [GAP_W-1:0] cfg_gap,
  input  logic             cfg_write,
  input  logic             cfg_seq,
  input  logic             cfg_shadow,
  input  logic [2:0]       cfg_addr,
  input  logic             cfg_range,
  input  logic             cfg_coding,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_din,
  input  logic             adc_dout,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [2:0]       res_chan,
  output logic [12:0]      res_sample,
  output logic             res_twos,
  output logic             res_tag_err
);
  ctrl_t                 ctrl;
  logic [FRAME_BITS-1:0] word;
  logic [FRAME_BITS-1:0] rx;
  logic go, rise_stb, fall_stb, done;

  assign ctrl = '{wr: cfg_write, seq: cfg_seq, addr: cfg_addr,
                  shadow: cfg_shadow, range_dbl: cfg_range, twos: cfg_coding};
  assign word = pack_ctrl(ctrl);

  sadc_timing #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u_timing (
    .clk(clk), .rst_n(rst_n), .en(en), .hold_off(res_valid),
    .half_div(cfg_half), .gap_min(cfg_gap),
    .cs_n(adc_cs_n), .sclk(adc_sclk), .go(go),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .done(done)
  );

  sadc_shift u_shift (
    .clk(clk), .rst_n(rst_n), .go(go), .rise_stb(rise_stb),
    .fall_stb(fall_stb), .done(done), .load_word(word),
    .dout(adc_dout), .din(adc_din), .rx(rx)
  );

  sadc_result u_result (
    .clk(clk), .rst_n(rst_n), .go(go), .twos_in(cfg_coding),
    .done(done), .rx(rx), .ready(res_ready), .valid(res_valid),
    .chan(res_chan), .sample(res_sample), .twos(res_twos),
    .tag_err(res_tag_err)
  );
endmodule

// File: rtl/sadc_host_chk.sv
module sadc_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        adc_cs_n,
  input logic        adc_sclk,
  input logic        adc_din,
  input logic        res_valid,
  input logic        res_ready,
  input logic [2:0]  res_chan,
  input logic [12:0] res_sample,
  input logic        res_twos,
  input logic        res_tag_err
);
  // R3
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> adc_sclk);

  // R4
  din_steady_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sclk) |-> $stable(adc_din));

  // R2
  no_start_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> !$past(res_valid));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_sample) &&
      $stable(res_chan) && $stable(res_twos) && $stable(res_tag_err)));

  // R9
  valid_with_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $rose(adc_cs_n));

  // R8
  unsigned_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_twos) |-> !res_sample[12]);
endmodule

bind sadc_host sadc_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
  .adc_din(adc_din), .res_valid(res_valid), .res_ready(res_ready),
  .res_chan(res_chan), .res_sample(res_sample), .res_twos(res_twos),
  .res_tag_err(res_tag_err)
);

// File: tb/sadc_host_test.sv
module sadc_host_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  cfg_half = 8'd1;
  logic [7:0]  cfg_gap = 8'd2;
  logic        cfg_write = 1'b1, cfg_seq = 1'b0, cfg_shadow = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic        cfg_range = 1'b0, cfg_coding = 1'b0;
  logic        adc_cs_n, adc_sclk, adc_din;
  logic        adc_dout = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [2:0]  res_chan;
  logic [12:0] res_sample;
  logic        res_twos, res_tag_err;

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 1'b0, finished = 1'b0;

  always #4 clk = ~clk;

  sadc_host uut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_half(cfg_half), .cfg_gap(cfg_gap),
    .cfg_write(cfg_write), .cfg_seq(cfg_seq), .cfg_shadow(cfg_shadow),
    .cfg_addr(cfg_addr), .cfg_range(cfg_range), .cfg_coding(cfg_coding),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
    .adc_dout(adc_dout), .res_valid(res_valid), .res_ready(res_ready),
    .res_chan(res_chan), .res_sample(res_sample), .res_twos(res_twos),
    .res_tag_err(res_tag_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] resp(input int f);
    logic [11:0] d;
    logic        mark;
    d = 12'((f * 1237 + 91) % 4096);
    case (f)
      2: d = 12'h800;
      3: d = 12'h7FF;
      4: d = 12'hFFF;
      6: d = 12'h000;
      default: ;
    endcase
    mark = (f == 5) || (f == 13);
    return {mark, 3'(f % 8), d};
  endfunction

  function automatic logic [15:0] cur_word();
    return {cfg_write, cfg_seq, 1'b0, cfg_addr, 2'b11, cfg_shadow, 1'b0,
            cfg_range, cfg_coding, 4'b0000};
  endfunction

  // behavioural reference model
  bit          m_active = 0, m_valid = 0, m_coding = 0, m_mid = 0;
  int          m_n = 0, m_H = 1, m_gap = 0, m_frame = 0;
  logic [15:0] m_word = '0;
  logic [2:0]  m_chan = '0;
  logic [12:0] m_sample = '0;
  bit          m_twos = 0, m_err = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_valid = 0; m_n = 0; m_gap = 0;
    end else begin
      bit old_valid;
      old_valid = m_valid;
      if (m_valid && res_ready) m_valid = 0;
      if (!m_active) begin
        if (en && m_gap >= int'(cfg_gap) && !old_valid) begin
          m_active = 1; m_n = 0;
          m_H = (cfg_half == 0) ? 1 : int'(cfg_half);
          m_word = cur_word(); m_coding = cfg_coding;
        end else if (m_gap < 255) m_gap++;
      end else begin
        m_n++;
        if (m_n == 32 * m_H) begin
          logic [15:0] r;
          r = resp(m_frame);
          m_frame++;
          m_active = 0; m_gap = 0; m_valid = 1;
          m_chan = r[14:12]; m_err = r[15]; m_twos = m_coding;
          m_sample = m_coding ? {r[11], r[11:0]} : {1'b0, r[11:0]};
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      bit e_sclk, e_din;
      int h;
      if (m_active) begin
        h = m_n / m_H;
        e_sclk = (h % 2 == 0);
        e_din = m_word[15 - h / 2];
      end else begin
        e_sclk = 1'b1; e_din = 1'b0;
      end
      chk(adc_cs_n === !m_active, "R2", "cs_n", adc_cs_n, !m_active);
      chk(adc_sclk === e_sclk, "R3", "sclk", adc_sclk, e_sclk);
      chk(adc_din === e_din, "R4", "din", adc_din, e_din);
      chk(res_valid === m_valid, "R9", "valid", res_valid, m_valid);
      if (m_valid) begin
        chk(res_chan === m_chan, "R6", "chan", res_chan, m_chan);
        chk(res_tag_err === m_err, "R7", "tag_err", res_tag_err, m_err);
        chk(res_sample === m_sample, "R8", "sample", res_sample, m_sample);
        chk(res_twos === m_twos, "R8", "twos", res_twos, m_twos);
      end
    end
  end

  // behavioural converter on the serial pins
  int          a_frame = 0, a_bit = 0, a_cnt = 0;
  logic [15:0] a_cur = '0, a_rx = '0;

  always @(negedge adc_cs_n) begin
    a_cur = resp(a_frame); a_frame++;
    a_bit = 0; a_cnt = 0; a_rx = '0;
    adc_dout = a_cur[15];
  end

  always @(negedge adc_sclk) begin
    if (adc_cs_n === 1'b0) begin
      a_rx = {a_rx[14:0], adc_din};
      a_cnt++; a_bit++;
      adc_dout = (a_bit < 16) ? a_cur[15 - a_bit] : 1'b0;
    end
  end

  always @(posedge adc_cs_n) begin
    if (rst_n && a_frame > 0) begin
      chk(a_cnt == 16, "R3", "sclk falls per frame", a_cnt, 16);
      chk(a_rx === m_word, m_mid ? "R5" : "R4", "control word", a_rx, m_word);
      m_mid = 0;
    end
  end

  task automatic wait_frames(input int n);
    while (m_frame < n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(adc_cs_n === 1'b1, "R1", "cs_n", adc_cs_n, 1);
    chk(adc_sclk === 1'b1, "R1", "sclk", adc_sclk, 1);
    chk(adc_din === 1'b0, "R1", "din", adc_din, 0);
    chk(res_valid === 1'b0, "R1", "valid", res_valid, 0);
    rst_n = 1'b1; cmp_on = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    wait_frames(3);
    cfg_coding = 1'b1; cfg_half = 8'd2; cfg_addr = 3'd5; cfg_seq = 1'b1;
    wait_frames(6);
    // R5: rewrite fields while a frame is running
    while (adc_cs_n !== 1'b0) @(negedge clk);
    repeat (5) @(negedge clk);
    m_mid = 1;
    cfg_coding = 1'b0; cfg_half = 8'd0; cfg_addr = 3'd2; cfg_range = 1'b1;
    cfg_shadow = 1'b1; cfg_write = 1'b0;
    wait_frames(8);
    // R9 back-pressure: result held, next frame blocked
    res_ready = 1'b0;
    repeat (150) @(negedge clk);
    chk(m_frame == 8, "R9", "frames during stall", m_frame, 8);
    res_ready = 1'b1;
    cfg_half = 8'd3; cfg_gap = 8'd0; cfg_coding = 1'b1;
    wait_frames(14);
    // R2: disabled, no frames
    en = 1'b0;
    repeat (120) @(negedge clk);
    chk(m_frame == 14 && adc_cs_n === 1'b1, "R2", "frames while disabled", m_frame, 14);
    cfg_gap = 8'd40; en = 1'b1;
    wait_frames(16);
    repeat (20) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule